// File: doc/BRIEF.md
# Three-Port Bus Router

The router sits between a processor core and three AHB-Lite master ports. It accepts requests from three sources: the data side of the core, its instruction side, and a debug port. Each request goes to exactly one of three 32-bit master ports: an instruction code port, a data code port and a system port. The choice depends on both the address region and the source. Code-region fetches from the instruction side are kept apart from code-region data and debug traffic, so a fetch and a load can run in the same cycle.

Each source uses a simple request interface. The source raises `src_req_i` with its address, direction, size and write data, and holds them until `src_gnt_o`. It then waits for `src_rvalid_o`, which carries the read data and the error flag. A source has at most one transfer in flight. On each master port the router drives the address phase, and it drives registered write data in the data phase. When two or more sources want the same port, a fixed priority decides. An address phase that the port has not yet accepted keeps its owner.

Top module: `bus_router`

## Requirements
- R1: An instruction-side request (source index 1) with an address below 0x2000_0000 appears on the instruction code port (port index 0).
- R2: A data-side request (source 0) or a debug request (source 2) with an address below 0x2000_0000 appears on the data code port (port index 1).
- R3: A request from any source with an address of 0x2000_0000 or above appears on the system port (port index 2).
- R4: A port presenting an address phase drives htrans 2'b10, with haddr, hwrite and hsize taken from the winning source. A port with nothing to present drives htrans 2'b00.
- R5: When several eligible sources target one free port, the lowest source index wins: data side, then instruction side, then debug.
- R6: While a port holds hready low, its pending address phase keeps the same owner and the same haddr, even if a higher-priority source arrives.
- R7: `src_gnt_o` is high, combinationally, in the cycle in which the selected port has the source's address phase and hready high. It is low while hready is low.
- R8: Write data captured at grant appears on that port's hwdata during the following data phase.
- R9: rvalid, rdata and err are returned only to the source that owns the port's data phase, in the cycle the port raises hready. err follows the port's hresp.
- R10: A source with a transfer in flight is not granted, and does not appear on any port, until its rvalid has been returned.
- R11: After reset every port drives htrans 2'b00 and hwdata zero, and no source sees rvalid.
- R12: Sources that target different ports are all granted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_req_i | input | 3 | Request per source (0 data, 1 instruction, 2 debug) |
| src_addr_i | input | 3x32 | Request address per source |
| src_write_i | input | 3 | 1 = write |
| src_size_i | input | 3x3 | Transfer size per source |
| src_wdata_i | input | 3x32 | Write data, held with the request |
| src_gnt_o | output | 3 | Address phase accepted |
| src_rvalid_o | output | 3 | Data phase complete |
| src_rdata_o | output | 3x32 | Read data |
| src_err_o | output | 3 | Error response |
| m_htrans_o | output | 3x2 | htrans per port (0 icode, 1 dcode, 2 system) |
| m_haddr_o | output | 3x32 | haddr per port |
| m_hwrite_o | output | 3 | hwrite per port |
| m_hsize_o | output | 3x3 | hsize per port |
| m_hwdata_o | output | 3x32 | hwdata per port |
| m_hready_i | input | 3 | hready per port |
| m_hrdata_i | input | 3x32 | hrdata per port |
| m_hresp_i | input | 3 | hresp per port |

## Verification
A wrong decode shows up in the same cycle as the request: an active htrans on the wrong port, or a grant that never arrives. A lost hold or a corrupt data-phase owner shows up one cycle after a stalled or accepted address phase. It appears as a changed haddr under low hready, or as rvalid and rdata delivered to the wrong source. A stuck in-flight flag either blocks a source for good or lets it onto a port before its response has come back. The bench drives wait states and contention so that each of these becomes visible.

// File: rtl/bus_router_pkg.sv
package bus_router_pkg;
  localparam int NUM_SRC  = 3;
  localparam int NUM_PORT = 3;
  localparam int IDX_W    = 2;

  typedef enum logic [IDX_W-1:0] {
    SRC_DATA  = 2'd0,
    SRC_INSTR = 2'd1,
    SRC_DEBUG = 2'd2
  } src_e;

  typedef enum logic [IDX_W-1:0] {
    PORT_ICODE = 2'd0,
    PORT_DCODE = 2'd1,
    PORT_SYS   = 2'd2
  } port_e;

  localparam logic [1:0] TRANS_IDLE   = 2'b00;
  localparam logic [1:0] TRANS_NONSEQ = 2'b10;
endpackage

// File: rtl/bus_router_decode.sv
module bus_router_decode
  import bus_router_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] CODE_LIMIT = 32'h2000_0000,
  parameter int                SRC        = 0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output port_e             port_o
);
  logic in_code;
  assign in_code = (addr_i < CODE_LIMIT);

  generate
    if (SRC == int'(SRC_INSTR)) begin : g_fetch
      assign port_o = in_code ? PORT_ICODE : PORT_SYS;
    end else begin : g_data
      assign port_o = in_code ? PORT_DCODE : PORT_SYS;
    end
  endgenerate
endmodule

// File: rtl/bus_router_arb.sv
module bus_router_arb #(
  parameter int NUM_REQ = 3,
  parameter int IDX_W   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REQ-1:0] req_i,
  input  logic               hready_i,
  output logic               win_valid_o,
  output logic [IDX_W-1:0]   win_idx_o,
  output logic [NUM_REQ-1:0] gnt_o
);
  logic             hold_q;
  logic [IDX_W-1:0] hold_idx_q;

  // a stalled address phase keeps its owner; else lowest index wins
  always_comb begin
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    if (hold_q) begin
      win_valid_o = 1'b1;
      win_idx_o   = hold_idx_q;
    end else begin
      for (int i = NUM_REQ - 1; i >= 0; i--) begin
        if (req_i[i]) begin
          win_valid_o = 1'b1;
          win_idx_o   = IDX_W'(i);
        end
      end
    end
  end

  always_comb begin
    gnt_o = '0;
    if (win_valid_o && hready_i) gnt_o[win_idx_o] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q     <= 1'b0;
      hold_idx_q <= '0;
    end else begin
      hold_q <= win_valid_o && !hready_i;
      if (win_valid_o && !hready_i) hold_idx_q <= win_idx_o;
    end
  end
endmodule

// File: rtl/bus_router_dphase.sv
module bus_router_dphase #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hready_i,
  input  logic              addr_valid_i,
  input  logic [IDX_W-1:0]  addr_idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              dph_valid_o,
  output logic [IDX_W-1:0]  dph_idx_o,
  output logic [DATA_W-1:0] hwdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dph_valid_o <= 1'b0;
      dph_idx_o   <= '0;
      hwdata_o    <= '0;
    end else if (hready_i) begin
      dph_valid_o <= addr_valid_i;
      dph_idx_o   <= addr_idx_i;
      if (addr_valid_i) hwdata_o <= wdata_i;
    end
  end
endmodule

// File: rtl/bus_router.sv
module bus_router
  import bus_router_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter int                DATA_W     = 32,
  parameter logic [ADDR_W-1:0] CODE_LIMIT = 32'h2000_0000
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_SRC-1:0]                src_req_i,
  input  logic [NUM_SRC-1:0][ADDR_W-1:0]    src_addr_i,
  input  logic [NUM_SRC-1:0]                src_write_i,
  input  logic [NUM_SRC-1:0][2:0]           src_size_i,
  input  logic [NUM_SRC-1:0][DATA_W-1:0]    src_wdata_i,
  output logic [NUM_SRC-1:0]                src_gnt_o,
  output logic [NUM_SRC-1:0]                src_rvalid_o,
  output logic [NUM_SRC-1:0][DATA_W-1:0]    src_rdata_o,
  output logic [NUM_SRC-1:0]                src_err_o,
  output logic [NUM_PORT-1:0][1:0]          m_htrans_o,
  output logic [NUM_PORT-1:0][ADDR_W-1:0]   m_haddr_o,
  output logic [NUM_PORT-1:0]               m_hwrite_o,
  output logic [NUM_PORT-1:0][2:0]          m_hsize_o,
  output logic [NUM_PORT-1:0][DATA_W-1:0]   m_hwdata_o,
  input  logic [NUM_PORT-1:0]               m_hready_i,
  input  logic [NUM_PORT-1:0][DATA_W-1:0]   m_hrdata_i,
  input  logic [NUM_PORT-1:0]               m_hresp_i
);
  port_e [NUM_SRC-1:0]                tgt;
  logic  [NUM_SRC-1:0]                busy_q;
  logic  [NUM_SRC-1:0]                elig;
  logic  [NUM_PORT-1:0][NUM_SRC-1:0]  port_req;
  logic  [NUM_PORT-1:0][NUM_SRC-1:0]  port_gnt;
  logic  [NUM_PORT-1:0]               win_v;
  logic  [NUM_PORT-1:0][IDX_W-1:0]    win_idx;
  logic  [NUM_PORT-1:0]               dph_v;
  logic  [NUM_PORT-1:0][IDX_W-1:0]    dph_idx;

  assign elig = src_req_i & ~busy_q;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    bus_router_decode #(
      .ADDR_W(ADDR_W), .CODE_LIMIT(CODE_LIMIT), .SRC(s)
    ) u_dec (
      .addr_i(src_addr_i[s]),
      .port_o(tgt[s])
    );
    for (genvar p = 0; p < NUM_PORT; p++) begin : g_req
      assign port_req[p][s] = elig[s] && (tgt[s] == port_e'(p));
    end
  end

  for (genvar p = 0; p < NUM_PORT; p++) begin : g_port
    bus_router_arb #(.NUM_REQ(NUM_SRC), .IDX_W(IDX_W)) u_arb (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .req_i      (port_req[p]),
      .hready_i   (m_hready_i[p]),
      .win_valid_o(win_v[p]),
      .win_idx_o  (win_idx[p]),
      .gnt_o      (port_gnt[p])
    );

    bus_router_dphase #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_dph (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .hready_i    (m_hready_i[p]),
      .addr_valid_i(win_v[p]),
      .addr_idx_i  (win_idx[p]),
      .wdata_i     (src_wdata_i[win_idx[p]]),
      .dph_valid_o (dph_v[p]),
      .dph_idx_o   (dph_idx[p]),
      .hwdata_o    (m_hwdata_o[p])
    );

    assign m_htrans_o[p] = win_v[p] ? TRANS_NONSEQ : TRANS_IDLE;
    assign m_haddr_o[p]  = win_v[p] ? src_addr_i[win_idx[p]]  : '0;
    assign m_hwrite_o[p] = win_v[p] ? src_write_i[win_idx[p]] : 1'b0;
    assign m_hsize_o[p]  = win_v[p] ? src_size_i[win_idx[p]]  : 3'd0;
  end

  always_comb begin
    src_gnt_o    = '0;
    src_rvalid_o = '0;
    src_rdata_o  = '0;
    src_err_o    = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      for (int p = 0; p < NUM_PORT; p++) begin
        if (port_gnt[p][s]) src_gnt_o[s] = 1'b1;
        if (dph_v[p] && m_hready_i[p] && (dph_idx[p] == IDX_W'(s))) begin
          src_rvalid_o[s] = 1'b1;
          src_rdata_o[s]  = m_hrdata_i[p];
          src_err_o[s]    = m_hresp_i[p];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= '0;
    else         busy_q <= (busy_q | src_gnt_o) & ~src_rvalid_o;
  end
endmodule

// File: rtl/bus_router_chk.sv
module bus_router_chk
  import bus_router_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter int                DATA_W     = 32,
  parameter logic [ADDR_W-1:0] CODE_LIMIT = 32'h2000_0000
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic [NUM_SRC-1:0]              src_req_i,
  input logic [NUM_SRC-1:0][ADDR_W-1:0]  src_addr_i,
  input logic [NUM_SRC-1:0]              src_gnt_o,
  input logic [NUM_SRC-1:0]              src_rvalid_o,
  input logic [NUM_PORT-1:0][1:0]        m_htrans_o,
  input logic [NUM_PORT-1:0][ADDR_W-1:0] m_haddr_o,
  input logic [NUM_PORT-1:0]             m_hready_i
);
  logic [NUM_SRC-1:0] out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else         out_q <= (out_q | src_gnt_o) & ~src_rvalid_o;
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_s
    // R10
    a_r10_single_flight: assert property (@(posedge clk_i) disable iff (!rst_ni)
      src_gnt_o[s] |-> !out_q[s]);
    // R9
    a_r9_resp_to_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
      src_rvalid_o[s] |-> out_q[s]);
  end

  for (genvar p = 0; p < NUM_PORT; p++) begin : g_p
    // R6
    a_r6_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (m_htrans_o[p][1] && !m_hready_i[p]) |=> (m_htrans_o[p][1] && $stable(m_haddr_o[p])));
  end

  // R1, R2
  a_r1_icode_region: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_htrans_o[0][1] |-> (m_haddr_o[0] < CODE_LIMIT));
  a_r2_dcode_region: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_htrans_o[1][1] |-> (m_haddr_o[1] < CODE_LIMIT));
  // R3
  a_r3_sys_region: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_htrans_o[2][1] |-> (m_haddr_o[2] >= CODE_LIMIT));
  // R5: a free data code port always goes to an eligible data-side request
  a_r5_data_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(m_hready_i[1]) && src_req_i[0] && !out_q[0] && (src_addr_i[0] < CODE_LIMIT))
      |-> (m_htrans_o[1][1] && (m_haddr_o[1] == src_addr_i[0]) && !src_gnt_o[2]));
endmodule

bind bus_router bus_router_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_LIMIT(CODE_LIMIT)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .src_req_i   (src_req_i),
  .src_addr_i  (src_addr_i),
  .src_gnt_o   (src_gnt_o),
  .src_rvalid_o(src_rvalid_o),
  .m_htrans_o  (m_htrans_o),
  .m_haddr_o   (m_haddr_o),
  .m_hready_i  (m_hready_i)
);

// File: tb/tb_bus_router.sv
module tb_bus_router;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] LIMIT = 32'h2000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0]        req = '0;
  logic [2:0][31:0]  addr = '0;
  logic [2:0]        write = '0;
  logic [2:0][2:0]   size = '0;
  logic [2:0][31:0]  wdata = '0;
  logic [2:0]        gnt, rvalid, err;
  logic [2:0][31:0]  rdata;
  logic [2:0][1:0]   htrans;
  logic [2:0][31:0]  haddr, hwdata;
  logic [2:0]        hwrite;
  logic [2:0][2:0]   hsize;
  logic [2:0]        hready = 3'b111;
  logic [2:0][31:0]  hrdata;
  logic [2:0]        hresp = '0;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar p = 0; p < 3; p++) begin : g_rd
    assign hrdata[p] = 32'hC0DE_0000 + p;
  end

  bus_router dut (
    .clk_i(clk), .rst_ni(rst_n),
    .src_req_i(req), .src_addr_i(addr), .src_write_i(write), .src_size_i(size),
    .src_wdata_i(wdata), .src_gnt_o(gnt), .src_rvalid_o(rvalid), .src_rdata_o(rdata),
    .src_err_o(err), .m_htrans_o(htrans), .m_haddr_o(haddr), .m_hwrite_o(hwrite),
    .m_hsize_o(hsize), .m_hwdata_o(hwdata), .m_hready_i(hready), .m_hrdata_i(hrdata),
    .m_hresp_i(hresp)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int exp_port(input int s, input logic [31:0] a);
    if (a >= LIMIT) return 2;
    return (s == 1) ? 0 : 1;
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic xfer(input int s, input logic [31:0] a, input logic w, input logic [31:0] wd);
    int p;
    string rt;
    p = exp_port(s, a);
    rt = (p == 0) ? "R1" : (p == 1) ? "R2" : "R3";
    step();
    req[s] = 1'b1; addr[s] = a; write[s] = w; size[s] = 3'd2; wdata[s] = wd;
    #1;
    chk({rt, " htrans"}, 32'(htrans[p]), 32'h2);
    chk({rt, " haddr"}, haddr[p], a);
    chk("R4 hwrite", 32'(hwrite[p]), 32'(w));
    chk("R4 hsize", 32'(hsize[p]), 32'd2);
    chk("R7 gnt", 32'(gnt), 32'(1 << s));
    for (int q = 0; q < 3; q++)
      if (q != p) chk("R4 idle port", 32'(htrans[q]), 32'h0);
    step();
    req[s] = 1'b0;
    #1;
    chk("R9 rvalid", 32'(rvalid), 32'(1 << s));
    if (w) chk("R8 hwdata", hwdata[p], wd);
    else   chk("R9 rdata", rdata[s], 32'hC0DE_0000 + 32'(p));
    chk("R4 idle after", 32'(htrans[p]), 32'h0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin : main
    logic [31:0] alist [4];
    alist[0] = 32'h0000_0000; alist[1] = 32'h1FFF_FFFC;
    alist[2] = 32'h2000_0000; alist[3] = 32'hFFFF_FFFC;

    #2;
    chk("R11 htrans", 32'(htrans), 32'h0);
    chk("R11 hwdata", hwdata[1], 32'h0);
    chk("R11 rvalid", 32'(rvalid), 32'h0);
    repeat (3) step();
    rst_n = 1'b1;
    step(); #1;
    chk("R11 idle after reset", 32'(htrans), 32'h0);

    // sweep: every source, region edge, direction
    for (int s = 0; s < 3; s++)
      for (int i = 0; i < 4; i++)
        for (int w = 0; w < 2; w++)
          xfer(s, alist[i] + 32'(4 * w), w[0], 32'hA500_0000 ^ (32'(s) << 8) ^ 32'(i * 2 + w));

    // R5: data side over debug on the data code port
    step();
    req[0] = 1; addr[0] = 32'h40; req[2] = 1; addr[2] = 32'h80; write = '0;
    #1;
    chk("R5 dcode haddr", haddr[1], 32'h40);
    chk("R5 gnt", 32'(gnt), 32'b001);
    step(); req[0] = 0; #1;
    chk("R5 debug next", 32'(gnt), 32'b100);
    chk("R5 debug haddr", haddr[1], 32'h80);
    chk("R9 data resp", 32'(rvalid), 32'b001);
    step(); req[2] = 0; #1;
    chk("R9 debug resp", 32'(rvalid), 32'b100);

    // R5: all three on the system port
    step();
    req = 3'b111; addr[0] = 32'h3000_0000; addr[1] = 32'h3000_0010; addr[2] = 32'h3000_0020;
    #1;
    chk("R5 sys d first", haddr[2], 32'h3000_0000);
    chk("R5 sys gnt d", 32'(gnt), 32'b001);
    step(); req[0] = 0; #1;
    chk("R5 sys i second", haddr[2], 32'h3000_0010);
    chk("R5 sys gnt i", 32'(gnt), 32'b010);
    step(); req[1] = 0; #1;
    chk("R5 sys gnt dbg", 32'(gnt), 32'b100);
    step(); req[2] = 0; #1;
    chk("R9 sys dbg resp", 32'(rvalid), 32'b100);

    // R6: stalled address phase keeps owner
    step();
    hready[1] = 0; req[2] = 1; addr[2] = 32'h100;
    #1;
    chk("R7 no gnt in stall", 32'(gnt), 32'h0);
    chk("R6 stalled haddr", haddr[1], 32'h100);
    step(); req[0] = 1; addr[0] = 32'h200; #1;
    chk("R6 owner kept", haddr[1], 32'h100);
    chk("R6 no gnt", 32'(gnt), 32'h0);
    step(); hready[1] = 1; #1;
    chk("R6 held owner granted", 32'(gnt), 32'b100);
    step(); req[2] = 0; #1;
    chk("R6 data next", haddr[1], 32'h200);
    chk("R6 data gnt", 32'(gnt), 32'b001);
    chk("R9 debug resp", 32'(rvalid), 32'b100);
    chk("R9 debug rdata", rdata[2], 32'hC0DE_0001);
    step(); req[0] = 0; #1;
    chk("R9 data resp", 32'(rvalid), 32'b001);

    // R12: three sources, three ports, one cycle
    step();
    req = 3'b111; addr[0] = 32'h4000_0000; addr[1] = 32'h0; addr[2] = 32'h10;
    #1;
    chk("R12 gnt all", 32'(gnt), 32'b111);
    chk("R12 icode", haddr[0], 32'h0);
    chk("R12 dcode", haddr[1], 32'h10);
    chk("R12 sys", haddr[2], 32'h4000_0000);
    step(); req = '0; #1;
    chk("R12 resp all", 32'(rvalid), 32'b111);
    chk("R12 rdata d", rdata[0], 32'hC0DE_0002);
    chk("R12 rdata i", rdata[1], 32'hC0DE_0000);

    // R9: error response with wait state
    step();
    req[0] = 1; addr[0] = 32'h2000_0010;
    #1;
    chk("R7 err gnt", 32'(gnt), 32'b001);
    step(); req[0] = 0; hready[2] = 0; hresp[2] = 1; #1;
    chk("R9 wait no rvalid", 32'(rvalid), 32'h0);
    step(); hready[2] = 1; #1;
    chk("R9 err rvalid", 32'(rvalid), 32'b001);
    chk("R9 err flag", 32'(err), 32'b001);
    step(); hresp[2] = 0;

    // R10: in-flight source blocked
    step();
    req[1] = 1; addr[1] = 32'h2000_0000;
    #1;
    chk("R10 first gnt", 32'(gnt), 32'b010);
    step(); addr[1] = 32'h0; hready[2] = 0; #1;
    chk("R10 blocked htrans", 32'(htrans[0]), 32'h0);
    chk("R10 blocked gnt", 32'(gnt), 32'h0);
    step(); hready[2] = 1; #1;
    chk("R10 resp", 32'(rvalid), 32'b010);
    chk("R10 still blocked", 32'(htrans[0]), 32'h0);
    step(); #1;
    chk("R10 released", 32'(htrans[0]), 32'h2);
    chk("R10 gnt after resp", 32'(gnt), 32'b010);
    step(); req[1] = 0; #1;
    chk("R10 second resp", 32'(rvalid), 32'b010);

    step();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule